// File: doc/BRIEF.md
# Up/Down Capture-Reload Timer

This block is a 16-bit timer/counter paired with a 16-bit register that works either as a reload source or as a capture target. It can count machine cycles or falling edges on an external count pin. It supports four behaviours: auto-reload on overflow, reload forced by an external trigger pin, capture of the running count on a trigger edge, and counting up or down under the control of the trigger pin level. A baud mode clocks the counter from a fast oscillator-derived enable. In that mode each reload produces a one-cycle pulse for a serial port's bit clock, and the overflow flag is held off.

Software reaches the block through a byte-wide register port, and reads return one cycle after the address is presented. The overflow flag and the external-event flag are sticky. Their OR forms the interrupt request. Both pins pass through a synchroniser before any edge is detected. Edges are evaluated only on machine-cycle enables, so the count pin cannot be counted faster than once every two machine cycles.

Top module: `updown_capture_timer`

## Requirements
- R1: With run set and counter-select clear, the count advances by one on each clock where `cyc_en` is high. With counter-select set, it advances once for each falling edge of `cnt_pin`. A falling edge is seen only when, on a `cyc_en` clock, the synchronised level is 0 and it was 1 on the previous `cyc_en` sample.
- R2: In auto-reload mode (capture bit clear, baud bits clear, up/down bit clear), a count step from FFFFh loads the reload register value and sets the overflow flag (control bit 7).
- R3: In auto-reload mode with ext-enable (control bit 3) and run set, a synchronised falling edge on `trig_pin` loads the reload value into the counter and sets the external flag (control bit 6).
- R4: With the up/down bit (mode register bit 0) set in auto-reload mode, a high synchronised `trig_pin` level counts up and a low level counts down. Trigger edges then neither reload the counter nor set the external flag.
- R5: When counting down, a step taken while the counter equals the reload value loads FFFFh and sets the overflow flag. Otherwise the step subtracts one.
- R6: In capture mode (control bit 0) with ext-enable set, a trigger falling edge copies the counter value from before that clock into the reload/capture register and sets the external flag. An up-count overflow in capture mode wraps to 0000h and sets the overflow flag.
- R7: When either baud bit (control bits 4 and 5) is set, the counter steps on `fast_en` rather than `cyc_en`. An overflow reloads the counter, leaves the overflow flag clear, and raises `baud_tick` for exactly the one clock after the step. A trigger falling edge with ext-enable set raises the external flag only.
- R8: With run clear, the counter holds its value under any pin activity.
- R9: Reset clears the control register (address 0), the mode register (address 1), the counter (addresses 2 low and 3 high) and the reload register (addresses 4 low and 5 high). Control bits are: 0 capture, 1 counter-select, 2 run, 3 ext-enable, 4 and 5 baud selects, 6 external flag, 7 overflow flag. Reads return data one clock after `rd_addr`.
- R10: `irq` is high whenever either flag is set. The flags stay set until software writes 0 to them through the control register.
- R11: With ext-enable clear, trigger edges neither change the counter nor set the external flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle enable |
| fast_en | input | 1 | Fast enable used in baud mode |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger / direction pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse on each baud-mode reload |

## Verification
The bench goes after the points where the modes interact. It checks that a trigger edge reloads the counter in auto-reload mode but only captures in capture mode. A design that mixed these up would corrupt the count or lose the capture. The down-count boundary at the reload value must give FFFFh and a flag; an off-by-one design would step one count too far or stop at zero. In baud mode the bench checks that no overflow flag appears and that `baud_tick` lasts exactly one clock. It also checks that trigger edges are ignored when ext-enable is clear or up/down mode is active. Designs getting these wrong would raise spurious interrupts or reload in the middle of a count.

// File: rtl/utm_pkg.sv
package utm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

  typedef struct packed {
    logic ovf;
    logic xflag;
    logic brx;
    logic btx;
    logic xen;
    logic run;
    logic csel;
    logic cap;
  } ctrl_t;
endpackage

// File: rtl/utm_pin_sync.sv
module utm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic pin,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      prev <= 1'b0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], pin};
      if (sample_en) prev <= sh_q[STAGES-1];
    end
  end

  assign cur = sh_q[STAGES-1];

  assert_prev_follows_R1: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (prev == $past(cur)));
endmodule

// File: rtl/utm_count_core.sv
module utm_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         down,
  input  logic         ovf_reload,
  input  logic         trig_reload,
  input  logic         capture,
  input  logic         cnt_wr_lo,
  input  logic         cnt_wr_hi,
  input  logic         rld_wr_lo,
  input  logic         rld_wr_hi,
  input  logic [W/2-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic         wrap
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_nx;

  assign wrap = tick & (down ? (cnt == rld) : (cnt == ALL1));

  always_comb begin
    cnt_nx = cnt;
    if (tick) begin
      if (down) cnt_nx = (cnt == rld) ? ALL1 : cnt - 1'b1;
      else if (cnt == ALL1) cnt_nx = ovf_reload ? rld : '0;
      else cnt_nx = cnt + 1'b1;
    end
    if (trig_reload) cnt_nx = rld;
    if (cnt_wr_lo) cnt_nx[HW-1:0] = wdata;
    if (cnt_wr_hi) cnt_nx[W-1:HW] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      cnt <= cnt_nx;
      if (capture) rld <= cnt;
      if (rld_wr_lo) rld[HW-1:0] <= wdata;
      if (rld_wr_hi) rld[W-1:HW] <= wdata;
    end
  end

  logic no_wr;
  assign no_wr = !cnt_wr_lo && !cnt_wr_hi && !rld_wr_lo && !rld_wr_hi;

  assert_up_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !down && cnt == ALL1 && ovf_reload && !trig_reload && no_wr)
      |=> (cnt == $past(rld)));
  assert_down_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && down && cnt == rld && !trig_reload && no_wr) |=> (cnt == ALL1));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !trig_reload && no_wr) |=> $stable(cnt));
endmodule

// File: rtl/updown_capture_timer.sv
module updown_capture_timer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_en,
  input  logic       fast_en,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ovf_flag,
  output logic       ext_flag,
  output logic       irq,
  output logic       baud_tick
);
  import utm_pkg::*;

  localparam int NPINS = 2;
  localparam int P_CNT = 0;
  localparam int P_TRG = 1;

  ctrl_t ctrl_q;
  logic  updn_q;

  logic [NPINS-1:0] pins, p_cur, p_prev, p_fall;
  assign pins = {trig_pin, cnt_pin};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    utm_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .sample_en(cyc_en), .pin(pins[g]),
      .cur(p_cur[g]), .prev(p_prev[g])
    );
    assign p_fall[g] = cyc_en & p_prev[g] & ~p_cur[g];
  end

  logic baud, tick, down, trig_ev, trig_reload, capture, ovf_reload;
  logic wrap, ovf_set, xflag_set, ctrl_wr;
  logic [CNT_W-1:0] cnt, rld;

  assign baud        = ctrl_q.btx | ctrl_q.brx;
  assign tick        = ctrl_q.run & (ctrl_q.csel ? p_fall[P_CNT] : (baud ? fast_en : cyc_en));
  assign down        = updn_q & ~baud & ~ctrl_q.cap & ~p_cur[P_TRG];
  assign trig_ev     = ctrl_q.xen & p_fall[P_TRG];
  assign trig_reload = trig_ev & ctrl_q.run & ~ctrl_q.cap & ~baud & ~updn_q;
  assign capture     = trig_ev & ctrl_q.cap & ~baud;
  assign ovf_reload  = baud | ~ctrl_q.cap;
  assign xflag_set   = trig_ev & (baud | ctrl_q.cap | ~updn_q);
  assign ovf_set     = wrap & ~baud;
  assign ctrl_wr     = wr_en && wr_addr == A_CTRL;

  utm_count_core #(.W(CNT_W)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .down(down), .ovf_reload(ovf_reload),
    .trig_reload(trig_reload), .capture(capture),
    .cnt_wr_lo(wr_en && wr_addr == A_CNT_LO), .cnt_wr_hi(wr_en && wr_addr == A_CNT_HI),
    .rld_wr_lo(wr_en && wr_addr == A_RLD_LO), .rld_wr_hi(wr_en && wr_addr == A_RLD_HI),
    .wdata(wr_data), .cnt(cnt), .rld(rld), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      updn_q    <= 1'b0;
      baud_tick <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data);
      if (ovf_set) ctrl_q.ovf <= 1'b1;
      if (xflag_set) ctrl_q.xflag <= 1'b1;
      if (wr_en && wr_addr == A_MODE) updn_q <= wr_data[0];
      baud_tick <= wrap & baud;
      case (rd_addr)
        A_CTRL:   rd_data <= ctrl_q;
        A_MODE:   rd_data <= {7'd0, updn_q};
        A_CNT_LO: rd_data <= cnt[DATA_W-1:0];
        A_CNT_HI: rd_data <= cnt[CNT_W-1:DATA_W];
        A_RLD_LO: rd_data <= rld[DATA_W-1:0];
        A_RLD_HI: rd_data <= rld[CNT_W-1:DATA_W];
        default:  rd_data <= '0;
      endcase
    end
  end

  assign ovf_flag = ctrl_q.ovf;
  assign ext_flag = ctrl_q.xflag;
  assign irq      = ctrl_q.ovf | ctrl_q.xflag;

  assert_baud_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (baud && !ctrl_q.ovf && !ctrl_wr) |=> !ctrl_q.ovf);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ovf && !ctrl_wr) |=> ctrl_q.ovf);
  assert_xen_off_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.xen && !ctrl_q.xflag && !ctrl_wr) |=> !ctrl_q.xflag);
  assert_fall_single_R1: assert property (@(posedge clk) disable iff (rst)
    p_fall[P_CNT] |=> !p_fall[P_CNT]);
endmodule

// File: tb/test_updown_capture_timer.sv
module test_updown_capture_timer;
  logic clk = 1'b0, rst = 1'b1;
  logic cyc_en = 0, fast_en = 0, cnt_pin = 1, trig_pin = 1, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ovf_flag, ext_flag, irq, baud_tick;
  int checks = 0, failures = 0;
  logic [7:0] b;
  logic [15:0] w;

  always #10 clk = ~clk;

  updown_capture_timer i_updown_capture_timer (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .fast_en(fast_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .irq(irq), .baud_tick(baud_tick)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic rd16(logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic set16(logic [2:0] a, logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_en = 1;
      @(negedge clk); cyc_en = 0;
    end
  endtask

  task automatic set_trig(logic v);
    @(negedge clk); trig_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(3'd0, b); chk("R9 ctrl reset", b, 8'h00);
    rd(3'd1, b); chk("R9 mode reset", b, 8'h00);
    rd16(3'd2, w); chk("R9 counter reset", w, 16'h0000);
    rd16(3'd4, w); chk("R9 reload reset", w, 16'h0000);
    chk("R10 irq reset", irq, 1'b0);
    chk("R9 baud_tick reset", baud_tick, 1'b0);
  endtask

  task automatic t_timer;
    set16(3'd2, 16'h0010); wr(3'd0, 8'h04);
    cyc(5); wr(3'd0, 8'h00);
    rd16(3'd2, w); chk("R1 timer counts cyc_en", w, 16'h0015);
  endtask

  task automatic t_counter;
    set16(3'd2, 16'h0000); wr(3'd0, 8'h06);
    @(negedge clk); cyc_en = 1;
    for (int i = 0; i < 3; i++) begin
      repeat (4) @(negedge clk); cnt_pin = 0;
      repeat (4) @(negedge clk); cnt_pin = 1;
    end
    repeat (4) @(negedge clk); cyc_en = 0;
    wr(3'd0, 8'h02);
    rd16(3'd2, w); chk("R1 counter counts pin falls", w, 16'h0003);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); cyc_en = 1; cnt_pin = 0;
      repeat (4) @(negedge clk); cnt_pin = 1;
      repeat (4) @(negedge clk);
    end
    cyc_en = 0;
    rd16(3'd2, w); chk("R8 stopped counter holds", w, 16'h0003);
  endtask

  task automatic t_reload;
    set16(3'd2, 16'hFFFE); set16(3'd4, 16'h1234); wr(3'd0, 8'h04);
    cyc(2);
    rd16(3'd2, w); chk("R2 overflow reloads", w, 16'h1234);
    rd(3'd0, b); chk("R2 overflow flag", b, 8'h84);
    chk("R10 irq on ovf", irq, 1'b1);
    cyc(1);
    rd(3'd0, b); chk("R10 flag sticky", b, 8'h84);
    wr(3'd0, 8'h00);
    rd(3'd0, b); chk("R10 software clear", b, 8'h00);
    chk("R10 irq cleared", irq, 1'b0);
  endtask

  task automatic t_trig_reload;
    set16(3'd2, 16'h0100); set16(3'd4, 16'h4000); wr(3'd0, 8'h0C);
    set_trig(0); cyc(1);
    rd16(3'd2, w); chk("R3 trigger reload", w, 16'h4000);
    rd(3'd0, b); chk("R3 external flag", b, 8'h4C);
    chk("R10 irq on ext", irq, 1'b1);
    set_trig(1); wr(3'd0, 8'h00); cyc(1);
    set16(3'd2, 16'h0100); wr(3'd0, 8'h04);
    set_trig(0); cyc(1);
    rd16(3'd2, w); chk("R11 no reload when ext-enable clear", w, 16'h0101);
    rd(3'd0, b); chk("R11 no ext flag", b, 8'h04);
    wr(3'd0, 8'h00); set_trig(1); cyc(1);
  endtask

  task automatic t_updown;
    wr(3'd1, 8'h01); set16(3'd4, 16'h0005); set16(3'd2, 16'h0007);
    wr(3'd0, 8'h08); set_trig(0); cyc(1);
    wr(3'd0, 8'h0C);
    cyc(2);
    rd16(3'd2, w); chk("R4 low level counts down", w, 16'h0005);
    rd(3'd0, b); chk("R4 trigger edge no flag in up/down", b, 8'h0C);
    cyc(1);
    rd16(3'd2, w); chk("R5 underflow loads FFFF", w, 16'hFFFF);
    rd(3'd0, b); chk("R5 underflow sets ovf", b, 8'h8C);
    wr(3'd0, 8'h08); set_trig(1); cyc(1);
    wr(3'd0, 8'h0C); cyc(1);
    rd16(3'd2, w); chk("R4 high level counts up, overflow reloads", w, 16'h0005);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_capture;
    set16(3'd4, 16'h0000); set16(3'd2, 16'h0AB0); wr(3'd0, 8'h0D);
    cyc(3);
    set_trig(0); cyc(1);
    rd16(3'd4, w); chk("R6 captured value", w, 16'h0AB3);
    rd16(3'd2, w); chk("R6 counter keeps running", w, 16'h0AB4);
    rd(3'd0, b); chk("R6 capture sets ext flag", b, 8'h4D);
    set16(3'd2, 16'hFFFF); cyc(1);
    rd16(3'd2, w); chk("R6 capture-mode overflow wraps", w, 16'h0000);
    rd(3'd0, b); chk("R6 capture-mode ovf flag", b, 8'hCD);
    rd16(3'd4, w); chk("R6 capture register unchanged by overflow", w, 16'h0AB3);
    wr(3'd0, 8'h00); set_trig(1); cyc(1);
  endtask

  task automatic fast1;
    @(negedge clk); fast_en = 1;
    @(negedge clk); fast_en = 0;
  endtask

  task automatic t_baud;
    set16(3'd4, 16'hFFFD); set16(3'd2, 16'hFFFE); wr(3'd0, 8'h1C);
    fast1; chk("R7 no tick before overflow", baud_tick, 1'b0);
    fast1; chk("R7 baud_tick on reload", baud_tick, 1'b1);
    @(negedge clk); chk("R7 baud_tick one clock", baud_tick, 1'b0);
    rd16(3'd2, w); chk("R7 baud reload", w, 16'hFFFD);
    rd(3'd0, b); chk("R7 no ovf flag in baud", b, 8'h1C);
    cyc(2);
    rd16(3'd2, w); chk("R7 cyc_en ignored in baud", w, 16'hFFFD);
    set_trig(0); cyc(1);
    rd(3'd0, b); chk("R7 trigger extra interrupt", b, 8'h5C);
    rd16(3'd2, w); chk("R7 trigger no reload in baud", w, 16'hFFFD);
    set_trig(1); cyc(1);
    wr(3'd0, 8'h24); set16(3'd2, 16'hFFFF);
    fast1; chk("R7 rx-select tick", baud_tick, 1'b1);
    rd16(3'd2, w); chk("R7 rx-select reload", w, 16'hFFFD);
    rd(3'd0, b); chk("R7 rx-select no ovf", b, 8'h24);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset; t_timer; t_counter; t_reload; t_trig_reload;
        t_updown; t_capture; t_baud;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule